// File: doc/BRIEF.md
# Systolic Complex Correlation Grid

This block is a square grid of complex multiply-accumulate cells. It is fed by two groups of complex sample lanes, one along the top of the grid and one along its side. In cross mode, every cell pairs one top lane with one side lane, so the grid forms all top-by-side products. In dual mode, the same cells are remapped. Cells above the diagonal pair two top lanes, cells below it pair two side lanes, and the diagonal cells stay idle. Self-products are never formed.

Each cell multiplies its first operand by the conjugate of its second and adds the result into a wrapping accumulator. A dump strobe copies every accumulator into a result register and starts a new integration period. A per-cell valid flag marks which results carry data. The input lanes are also registered and sent out again one clock later, so several grids can be chained without skew. In dual mode, the top lanes are routed to the side outputs.

Top module: `corr_grid`

## Requirements
- R1: While reset is asserted and after it is released, all results, valid flags, pass-through outputs, `dump_done_o` and `mode_dual_o` read zero. Zero on `mode_dual_o` means cross mode.
- R2: In cross mode, the cell at row r and column c has result index r*N+c. It adds top[r]·conj(side[c]). The real part is ar·br + ai·bi and the imaginary part is ai·br − ar·bi. Lanes are signed two's-complement DW-bit values; lane k occupies bits [k*DW +: DW]. The accumulator is AW bits wide and wraps modulo 2^AW.
- R3: In dual mode, a cell with r<c adds top[r]·conj(top[c]) and a cell with r>c adds side[r]·conj(side[c]). A diagonal cell adds nothing, and its result reads zero.
- R4: A dump that closes a cross period sets all N*N valid flags. A dump that closes a dual period sets only the off-diagonal flags.
- R5: A sample is accumulated only in a cycle where `sample_en` is high. Samples in other cycles have no effect on any result.
- R6: On a dump, each result takes the sum since the previous dump. A sample presented in the dump cycle itself counts toward the new period. `dump_done_o` is high in the cycle after the dump.
- R7: Results and valid flags keep their values in every cycle without a dump.
- R8: `mode_dual_req` is sampled only in a dump cycle. The new mode governs that cycle's sample and pass-through. `mode_dual_o` shows the active mode from the next cycle on.
- R9: In cross mode, the top outputs repeat the top inputs and the side outputs repeat the side inputs, each one clock later.
- R10: In dual mode, the side outputs repeat the top inputs and the top outputs repeat the side inputs, each one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_dual_req | input | 1 | Requested mode (1 = dual), taken at a dump |
| sample_en | input | 1 | Accumulate this cycle's sample |
| dump | input | 1 | Latch results and start a new period |
| top_re_i | input | N*DW | Top lanes, real parts |
| top_im_i | input | N*DW | Top lanes, imaginary parts |
| side_re_i | input | N*DW | Side lanes, real parts |
| side_im_i | input | N*DW | Side lanes, imaginary parts |
| top_re_o | output | N*DW | Registered pass-through, top real |
| top_im_o | output | N*DW | Registered pass-through, top imaginary |
| side_re_o | output | N*DW | Registered pass-through, side real |
| side_im_o | output | N*DW | Registered pass-through, side imaginary |
| mode_dual_o | output | 1 | Active mode |
| dump_done_o | output | 1 | Results updated in the last edge |
| res_re_o | output | N*N*AW | Latched real results, cell r*N+c |
| res_im_o | output | N*N*AW | Latched imaginary results |
| res_vld_o | output | N*N | Per-cell result valid |

## Verification
The interesting overlap is a dump that arrives in the same cycle as an enabled sample, sometimes together with a mode switch. The bench drives these cycles on purpose. It checks that the latched results exclude that sample, that the following period includes it under the newly requested mode, and that the pass-through routing switches in that same cycle. A second dump on the very next cycle isolates the overlapping sample, so its placement can be judged on its own.

// File: rtl/corr_pkg.sv
package corr_pkg;

    typedef enum logic [1:0] {
        ROLE_TS   = 2'd0,
        ROLE_TT   = 2'd1,
        ROLE_SS   = 2'd2,
        ROLE_IDLE = 2'd3
    } cell_role_e;

    // Operand pairing of a grid cell for a given mode.
    function automatic cell_role_e cell_role(input int r, input int c, input logic dual);
        if (!dual)  return ROLE_TS;
        if (r < c)  return ROLE_TT;
        if (r > c)  return ROLE_SS;
        return ROLE_IDLE;
    endfunction

endpackage

// File: rtl/corr_cell.sv
module corr_cell #(
    parameter int DW = 4,
    parameter int AW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] a_re,
    input  logic signed [DW-1:0] a_im,
    input  logic signed [DW-1:0] b_re,
    input  logic signed [DW-1:0] b_im,
    input  logic                 act_now,
    input  logic                 act_old,
    input  logic                 en,
    input  logic                 dump,
    output logic [AW-1:0]        res_re,
    output logic [AW-1:0]        res_im,
    output logic                 res_vld
);
    localparam int PW = 2 * DW + 1;

    typedef struct packed {
        logic [AW-1:0] acc_re;
        logic [AW-1:0] acc_im;
        logic [AW-1:0] res_re;
        logic [AW-1:0] res_im;
        logic          vld;
    } cell_st_t;

    cell_st_t st_d, st_q;

    logic signed [PW-1:0] xr, xi, yr, yi, p_re, p_im;
    logic [AW-1:0]        ext_re, ext_im;
    logic                 take;

    always_comb begin
        xr     = PW'(a_re);
        xi     = PW'(a_im);
        yr     = PW'(b_re);
        yi     = PW'(b_im);
        p_re   = xr * yr + xi * yi;
        p_im   = xi * yr - xr * yi;
        ext_re = {{(AW-PW){p_re[PW-1]}}, p_re};
        ext_im = {{(AW-PW){p_im[PW-1]}}, p_im};
        take   = en && act_now;

        st_d = st_q;
        if (dump) begin
            st_d.res_re = st_q.acc_re;
            st_d.res_im = st_q.acc_im;
            st_d.vld    = act_old;
            st_d.acc_re = take ? ext_re : '0;
            st_d.acc_im = take ? ext_im : '0;
        end else if (take) begin
            st_d.acc_re = st_q.acc_re + ext_re;
            st_d.acc_im = st_q.acc_im + ext_im;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_re  = st_q.res_re;
    assign res_im  = st_q.res_im;
    assign res_vld = st_q.vld;

    AST_CLEAR_ON_DUMP: assert property (@(posedge clk) disable iff (!rst_n)
        (dump && !(en && act_now)) |=> (st_q.acc_re == '0 && st_q.acc_im == '0)); // R6
    AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !dump |=> ($stable(res_re) && $stable(res_im) && $stable(res_vld))); // R7
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !res_vld |-> (res_re == '0 && res_im == '0)); // R3

endmodule

// File: rtl/corr_pass.sv
module corr_pass #(
    parameter int N  = 8,
    parameter int DW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dual,
    input  logic [N*DW-1:0] t_re_i,
    input  logic [N*DW-1:0] t_im_i,
    input  logic [N*DW-1:0] s_re_i,
    input  logic [N*DW-1:0] s_im_i,
    output logic [N*DW-1:0] t_re_o,
    output logic [N*DW-1:0] t_im_o,
    output logic [N*DW-1:0] s_re_o,
    output logic [N*DW-1:0] s_im_o
);
    localparam int W = N * DW;

    typedef struct packed {
        logic [W-1:0] t_re;
        logic [W-1:0] t_im;
        logic [W-1:0] s_re;
        logic [W-1:0] s_im;
    } pass_st_t;

    pass_st_t pass_d, pass_q;

    always_comb begin
        if (dual) begin
            pass_d.t_re = s_re_i;
            pass_d.t_im = s_im_i;
            pass_d.s_re = t_re_i;
            pass_d.s_im = t_im_i;
        end else begin
            pass_d.t_re = t_re_i;
            pass_d.t_im = t_im_i;
            pass_d.s_re = s_re_i;
            pass_d.s_im = s_im_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pass_q <= '0;
        else        pass_q <= pass_d;
    end

    assign t_re_o = pass_q.t_re;
    assign t_im_o = pass_q.t_im;
    assign s_re_o = pass_q.s_re;
    assign s_im_o = pass_q.s_im;

    AST_PASS_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(dual)) |-> (t_re_o == $past(t_re_i) && s_im_o == $past(s_im_i))); // R9
    AST_PASS_DUAL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(dual)) |-> (s_re_o == $past(t_re_i) && t_im_o == $past(s_im_i))); // R10

endmodule

// File: rtl/corr_grid.sv
module corr_grid
    import corr_pkg::*;
#(
    parameter int N  = 8,
    parameter int DW = 4,
    parameter int AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_dual_req,
    input  logic              sample_en,
    input  logic              dump,
    input  logic [N*DW-1:0]   top_re_i,
    input  logic [N*DW-1:0]   top_im_i,
    input  logic [N*DW-1:0]   side_re_i,
    input  logic [N*DW-1:0]   side_im_i,
    output logic [N*DW-1:0]   top_re_o,
    output logic [N*DW-1:0]   top_im_o,
    output logic [N*DW-1:0]   side_re_o,
    output logic [N*DW-1:0]   side_im_o,
    output logic              mode_dual_o,
    output logic              dump_done_o,
    output logic [N*N*AW-1:0] res_re_o,
    output logic [N*N*AW-1:0] res_im_o,
    output logic [N*N-1:0]    res_vld_o
);
    typedef struct packed {
        logic dual;
        logic done;
    } ctl_st_t;

    ctl_st_t ctl_d, ctl_q;
    logic    cur_dual;

    always_comb begin
        cur_dual   = dump ? mode_dual_req : ctl_q.dual;
        ctl_d      = ctl_q;
        ctl_d.done = dump;
        if (dump) ctl_d.dual = mode_dual_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign mode_dual_o = ctl_q.dual;
    assign dump_done_o = ctl_q.done;

    corr_pass #(.N(N), .DW(DW)) u_pass (
        .clk    (clk),
        .rst_n  (rst_n),
        .dual   (cur_dual),
        .t_re_i (top_re_i),
        .t_im_i (top_im_i),
        .s_re_i (side_re_i),
        .s_im_i (side_im_i),
        .t_re_o (top_re_o),
        .t_im_o (top_im_o),
        .s_re_o (side_re_o),
        .s_im_o (side_im_o)
    );

    for (genvar r = 0; r < N; r++) begin : g_row
        for (genvar c = 0; c < N; c++) begin : g_col
            localparam int IDX = r * N + c;
            cell_role_e           role_now;
            logic                 act_old;
            logic signed [DW-1:0] a_re, a_im, b_re, b_im;

            always_comb begin
                role_now = cell_role(r, c, cur_dual);
                act_old  = (cell_role(r, c, ctl_q.dual) != ROLE_IDLE);
                a_re = '0; a_im = '0; b_re = '0; b_im = '0;
                case (role_now)
                    ROLE_TS: begin
                        a_re = top_re_i[r*DW +: DW];  a_im = top_im_i[r*DW +: DW];
                        b_re = side_re_i[c*DW +: DW]; b_im = side_im_i[c*DW +: DW];
                    end
                    ROLE_TT: begin
                        a_re = top_re_i[r*DW +: DW];  a_im = top_im_i[r*DW +: DW];
                        b_re = top_re_i[c*DW +: DW];  b_im = top_im_i[c*DW +: DW];
                    end
                    ROLE_SS: begin
                        a_re = side_re_i[r*DW +: DW]; a_im = side_im_i[r*DW +: DW];
                        b_re = side_re_i[c*DW +: DW]; b_im = side_im_i[c*DW +: DW];
                    end
                    default: ;
                endcase
            end

            corr_cell #(.DW(DW), .AW(AW)) u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .a_re    (a_re),
                .a_im    (a_im),
                .b_re    (b_re),
                .b_im    (b_im),
                .act_now (role_now != ROLE_IDLE),
                .act_old (act_old),
                .en      (sample_en),
                .dump    (dump),
                .res_re  (res_re_o[IDX*AW +: AW]),
                .res_im  (res_im_o[IDX*AW +: AW]),
                .res_vld (res_vld_o[IDX])
            );
        end
    end

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !dump |=> $stable(mode_dual_o)); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        dump |=> dump_done_o); // R6
    AST_VLD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        dump_done_o |-> ($countones(res_vld_o) == N*N || $countones(res_vld_o) == N*N - N)); // R4

endmodule

// File: tb/sim_corr_grid.sv
module sim_corr_grid;
    localparam int N  = 8;
    localparam int DW = 4;
    localparam int AW = 16;
    localparam int NC = N * N;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mode_dual_req = 1'b0;
    logic              sample_en = 1'b0;
    logic              dump = 1'b0;
    logic [N*DW-1:0]   top_re_i = '0, top_im_i = '0, side_re_i = '0, side_im_i = '0;
    logic [N*DW-1:0]   top_re_o, top_im_o, side_re_o, side_im_o;
    logic              mode_dual_o, dump_done_o;
    logic [NC*AW-1:0]  res_re_o, res_im_o;
    logic [NC-1:0]     res_vld_o;

    corr_grid #(.N(N), .DW(DW), .AW(AW)) u0 (.*);

    always #5 clk = ~clk;

    typedef struct packed {
        logic [NC*AW-1:0] re;
        logic [NC*AW-1:0] im;
        logic [NC-1:0]    vld;
    } rec_t;

    rec_t q[$];
    rec_t last = '0;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    int acc_re[NC], acc_im[NC];
    bit mdl_dual = 0;
    bit drv_dual = 0;
    logic [N*DW-1:0] drv_tr = '0, drv_ti = '0, drv_sr = '0, drv_si = '0;

    function automatic int lane_val(int seed, int k, int lane);
        if (seed < 0) return -8;
        return ((seed * 7 + k * 3 + lane * 5 + seed * lane) % 16) - 8;
    endfunction

    // 0 cross pair, 1 top pair, 2 side pair, 3 idle
    function automatic int role_of(int r, int c, bit dual);
        if (!dual) return 0;
        if (r < c) return 1;
        if (r > c) return 2;
        return 3;
    endfunction

    task automatic drive(int seed, bit en, bit dmp, bit mreq);
        int tr[N], ti[N], sr[N], si[N];
        bit cur;
        rec_t rec;
        @(negedge clk);
        for (int l = 0; l < N; l++) begin
            tr[l] = lane_val(seed, 0, l); ti[l] = lane_val(seed, 1, l);
            sr[l] = lane_val(seed, 2, l); si[l] = lane_val(seed, 3, l);
            top_re_i[l*DW +: DW]  = DW'(tr[l]); top_im_i[l*DW +: DW]  = DW'(ti[l]);
            side_re_i[l*DW +: DW] = DW'(sr[l]); side_im_i[l*DW +: DW] = DW'(si[l]);
        end
        sample_en = en; dump = dmp; mode_dual_req = mreq;
        cur = dmp ? mreq : mdl_dual;
        if (dmp) begin
            for (int i = 0; i < NC; i++) begin
                rec.re[i*AW +: AW] = AW'(acc_re[i]);
                rec.im[i*AW +: AW] = AW'(acc_im[i]);
                rec.vld[i] = (role_of(i / N, i % N, mdl_dual) != 3);
                acc_re[i] = 0; acc_im[i] = 0;
            end
            q.push_back(rec);
            mdl_dual = mreq;
        end
        if (en) begin
            for (int r = 0; r < N; r++) begin
                for (int c = 0; c < N; c++) begin
                    int ro, ar, ai, br, bi;
                    ro = role_of(r, c, cur);
                    ar = (ro == 2) ? sr[r] : tr[r];
                    ai = (ro == 2) ? si[r] : ti[r];
                    br = (ro == 1) ? tr[c] : sr[c];
                    bi = (ro == 1) ? ti[c] : si[c];
                    if (ro != 3) begin
                        acc_re[r*N+c] += ar * br + ai * bi;
                        acc_im[r*N+c] += ai * br - ar * bi;
                    end
                end
            end
        end
        drv_dual = cur;
        drv_tr = top_re_i; drv_ti = top_im_i; drv_sr = side_re_i; drv_si = side_im_i;
    endtask

    task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: pass-through, mode, dumped results and hold between dumps
    initial begin
        forever begin
            @(posedge clk); #3;
            if (rst_n && !finished) begin
                if (drv_dual)
                    chk(top_re_o == drv_sr && top_im_o == drv_si && side_re_o == drv_tr && side_im_o == drv_ti,
                        "R10 dual pass", {top_re_o, side_re_o}, {drv_sr, drv_tr});
                else
                    chk(top_re_o == drv_tr && top_im_o == drv_ti && side_re_o == drv_sr && side_im_o == drv_si,
                        "R9 cross pass", {top_re_o, side_re_o}, {drv_tr, drv_sr});
                chk(mode_dual_o == mdl_dual, "R8 mode", 128'(mode_dual_o), 128'(mdl_dual));
                if (dump_done_o) begin
                    if (q.size() == 0) begin
                        chk(0, "R6 unexpected dump_done", 128'(1), 128'(0));
                    end else begin
                        last = q.pop_front();
                        for (int i = 0; i < NC; i++)
                            chk(res_re_o[i*AW +: AW] == last.re[i*AW +: AW] &&
                                res_im_o[i*AW +: AW] == last.im[i*AW +: AW],
                                "R2/R3/R5/R6 cell result",
                                {res_re_o[i*AW +: AW], res_im_o[i*AW +: AW]},
                                {last.re[i*AW +: AW], last.im[i*AW +: AW]});
                        chk(res_vld_o == last.vld, "R4 valid flags", 128'(res_vld_o), 128'(last.vld));
                    end
                end else begin
                    chk(res_re_o == last.re && res_im_o == last.im && res_vld_o == last.vld,
                        "R7 hold", 128'(res_re_o), 128'(last.re));
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NC; i++) begin acc_re[i] = 0; acc_im[i] = 0; end
        repeat (3) @(negedge clk);
        chk(res_re_o == '0 && res_im_o == '0 && res_vld_o == '0 && dump_done_o == 1'b0,
            "R1 reset results", 128'(res_vld_o), 128'(0));
        chk(mode_dual_o == 1'b0 && top_re_o == '0 && side_im_o == '0,
            "R1 reset mode/pass", 128'(mode_dual_o), 128'(0));
        rst_n = 1'b1;
        // R2 cross accumulation
        for (int k = 0; k < 6; k++) drive(k + 1, 1, 0, 0);
        drive(10, 0, 1, 0);
        // R5 gated samples, R8 request ignored without dump
        drive(3, 0, 0, 0); drive(4, 1, 0, 0); drive(5, 0, 0, 0);
        drive(6, 1, 0, 1); drive(7, 0, 0, 1);
        // R6 dump with a sample and a switch to dual in the same cycle
        drive(8, 1, 1, 1);
        for (int k = 9; k < 15; k++) drive(k, 1, 0, 0);
        // R3 dual results; overlapping sample isolated by back-to-back dumps
        drive(15, 1, 1, 1);
        drive(16, 0, 1, 0);
        drive(17, 0, 0, 0); drive(18, 0, 0, 0);
        // R2 wrap of the 16-bit accumulator
        for (int k = 0; k < 300; k++) drive(-1, 1, 0, 0);
        drive(0, 0, 1, 0);
        for (int k = 0; k < 6; k++) drive(k + 20, 0, 0, 0);
        if (q.size() != 0) chk(0, "R6 pending dumps", 128'(q.size()), 128'(0));
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule